// File: doc/BRIEF.md
# Parallel Port Mode and Interrupt Control

This block is the software-facing control plane of a bidirectional IEEE 1284 parallel port. A byte-wide CPU port reaches three registers. The mode register holds a 4-bit protocol mode and three interrupt enables. The event register holds three event flags, which software clears by writing 1 to them. The override register lets software force each of the four peripheral-side status lines (busy, paper error, acknowledge, fault) high or low. The handshake engines, the DMA engine and run-length expansion sit outside this block. They feed it event pulses and status-line values, and they take the selected mode and a reinitialise pulse from it.

Software must write the mode register with its "new mode" bit set to change the mode. That write loads the mode and starts a one-cycle reinitialise pulse, which sends the external protocol engine back to the entry state of that mode. The internal controller then settles into one of five named states:
- `ST_OFF`: non-1284 operation.
- `ST_REINIT`: the single reinitialise cycle.
- `ST_PERIPH`: any peripheral mode.
- `ST_HOST`: any host mode except the reserved one.
- `ST_INERT`: the reserved host mode, which is stored but does nothing.

The transitions are:
- `GO_REINIT`: from any state, on a mode write with the new-mode bit set.
- `SETTLE_OFF`, `SETTLE_PERIPH`, `SETTLE_HOST` and `SETTLE_INERT`: out of `ST_REINIT`, chosen by the stored mode.
- `HOLD`: every other cycle, where the state does not change.

An event may be raised by the act of entering a mode. Such an event is latched as a flag but is marked non-interrupting, so it never raises the interrupt request.

Top module: `ppc_mode_ctrl`

## Requirements
- R1: After reset, every register holds zero. `mode_sel`, `reinit`, `periph_act`, `host_act`, `mode_inert` and `irq` are all 0, and `pin_lines` equals `sm_lines`.
- R2: The mode register sits at address 0xD9. Bit 7 is new-mode, bit 6 is the idle enable, bit 5 is the status enable, bit 4 is the DREQ enable and bits 3:0 are the mode. A write always updates the enables. It updates the mode only when bit 7 is 1. A read returns bit 7 as 0.
- R3: A mode write with bit 7 set makes `reinit` 1 for exactly the cycle after the write, and `mode_sel` shows the new mode in that same cycle.
- R4: In the cycle after the reinitialise cycle, the activity outputs settle as follows. Mode 0000 drives all three low. Modes 0001 to 0111 raise `periph_act`. Mode 1101 raises `mode_inert`. Every other mode from 1000 to 1111 raises `host_act`.
- R5: When an idle or DREQ event arrives with `ev_entry` high, or during the reinitialise cycle, its flag is latched but does not raise `irq`.
- R6: `irq` is the OR, over all flags, of the flags that are set, enabled and interrupt-eligible.
- R7: The event register sits at address 0xDA. A read returns the idle flag in bit 0, the DREQ flag in bit 1, the status flag in bit 2 and `irq` in bit 7. Writing 1 to a flag bit clears that flag. If an event and a clear reach the same flag in the same cycle, the flag stays set.
- R8: The override register sits at address 0xDB. Bits 7:4 force busy, paper error, acknowledge and fault high, and bits 3:0 force the same four lines low. In `pin_lines` and `sm_lines` these lines sit at bits 3, 2, 1 and 0. In `ST_PERIPH`, a forced line takes its forced value, force-low wins over force-high, and an unforced line follows `sm_lines`.
- R9: Outside `ST_PERIPH` the override register has no effect, and `pin_lines` equals `sm_lines`.
- R10: `cpu_rdata` is 0 when `cpu_rd` is low, and also when `cpu_rd` reads an address that has no register.
- R11: A status event is always interrupt-eligible, whatever the state of `ev_entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | CPU register address |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read enable (combinational read) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| ev_idle | input | 1 | Idle event pulse from the protocol engine |
| ev_dreq | input | 1 | DREQ event pulse from the protocol engine |
| ev_stat | input | 1 | Status event pulse from the protocol engine |
| ev_entry | input | 1 | Qualifier: the current event comes from mode entry |
| sm_lines | input | 4 | Status lines as driven by the protocol engine |
| pin_lines | output | 4 | Status lines after software override |
| mode_sel | output | 4 | Selected protocol mode |
| reinit | output | 1 | One-cycle reinitialise pulse |
| periph_act | output | 1 | A peripheral mode is active |
| host_act | output | 1 | A usable host mode is active |
| mode_inert | output | 1 | The reserved host mode is held inert |
| irq | output | 1 | Interrupt request |

## Verification
A wrong controller state shows up at the ports one cycle after the reinitialise pulse. It appears as the wrong activity output, and in peripheral modes as overrides that are either applied or dropped wrongly on `pin_lines`. A wrong flag or eligibility bit shows up on `irq` in the cycle after the event edge, and in the event register read that follows. Every mode code, every override byte in a peripheral mode and in a host mode, and every combination of enable and flag is therefore swept, and each result is compared with values computed from the register layout.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int NFLAG = 3;
    localparam int NLINE = 4;

    localparam int FLG_IDLE = 0;
    localparam int FLG_DREQ = 1;
    localparam int FLG_STAT = 2;

    localparam int BIT_NEW     = 7;
    localparam int BIT_IDLE_EN = 6;
    localparam int BIT_STAT_EN = 5;
    localparam int BIT_DREQ_EN = 4;

    localparam logic [3:0] MODE_OFF  = 4'h0;
    localparam logic [3:0] MODE_RSVD = 4'hD;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_REINIT,
        ST_PERIPH,
        ST_HOST,
        ST_INERT
    } ctl_state_t;
endpackage

// File: rtl/ppc_regfile.sv
module ppc_regfile
    import ppc_pkg::*;
#(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] MODE_ADDR = 'hD9,
    parameter logic [AW-1:0] EVT_ADDR  = 'hDA,
    parameter logic [AW-1:0] OVR_ADDR  = 'hDB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       wdata,
    input  logic [NFLAG-1:0] flags_i,
    input  logic             irq_i,
    output logic [3:0]       mode_o,
    output logic [NFLAG-1:0] en_o,
    output logic [NLINE-1:0] ovr_hi_o,
    output logic [NLINE-1:0] ovr_lo_o,
    output logic             newmode_o,
    output logic [NFLAG-1:0] clr_o,
    output logic [7:0]       rdata_o
);
    logic [3:0]       mode_q;
    logic [NFLAG-1:0] en_q;
    logic [NLINE-1:0] hi_q, lo_q;
    logic             wr_mode, wr_evt, wr_ovr;

    always_comb begin
        wr_mode   = wr && (addr == MODE_ADDR);
        wr_evt    = wr && (addr == EVT_ADDR);
        wr_ovr    = wr && (addr == OVR_ADDR);
        newmode_o = wr_mode && wdata[BIT_NEW];
        clr_o     = wr_evt ? wdata[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            en_q   <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (wr_mode) begin
                en_q[FLG_IDLE] <= wdata[BIT_IDLE_EN];
                en_q[FLG_STAT] <= wdata[BIT_STAT_EN];
                en_q[FLG_DREQ] <= wdata[BIT_DREQ_EN];
                if (wdata[BIT_NEW]) begin
                    mode_q <= wdata[3:0];
                end
            end
            if (wr_ovr) begin
                hi_q <= wdata[7:4];
                lo_q <= wdata[3:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            if (addr == MODE_ADDR) begin
                rdata_o[BIT_IDLE_EN] = en_q[FLG_IDLE];
                rdata_o[BIT_STAT_EN] = en_q[FLG_STAT];
                rdata_o[BIT_DREQ_EN] = en_q[FLG_DREQ];
                rdata_o[3:0]         = mode_q;
            end else if (addr == EVT_ADDR) begin
                rdata_o[NFLAG-1:0] = flags_i;
                rdata_o[7]         = irq_i;
            end else if (addr == OVR_ADDR) begin
                rdata_o = {hi_q, lo_q};
            end
        end
    end

    assign mode_o   = mode_q;
    assign en_o     = en_q;
    assign ovr_hi_o = hi_q;
    assign ovr_lo_o = lo_q;

    // R2: the mode field moves only on a write carrying the new-mode bit
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !newmode_o |=> $stable(mode_q));
endmodule

// File: rtl/ppc_ctl_fsm.sv
module ppc_ctl_fsm
    import ppc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       newmode_i,
    input  logic [3:0] mode_i,
    output logic       reinit_o,
    output logic       periph_o,
    output logic       host_o,
    output logic       inert_o
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;                       // HOLD
        if (newmode_i) begin
            state_d = ST_REINIT;                 // GO_REINIT
        end else begin
            unique case (state_q)
                ST_REINIT: begin
                    if (mode_i == MODE_OFF)       state_d = ST_OFF;     // SETTLE_OFF
                    else if (!mode_i[3])          state_d = ST_PERIPH;  // SETTLE_PERIPH
                    else if (mode_i == MODE_RSVD) state_d = ST_INERT;   // SETTLE_INERT
                    else                          state_d = ST_HOST;    // SETTLE_HOST
                end
                ST_OFF, ST_PERIPH, ST_HOST, ST_INERT: state_d = state_q;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        reinit_o = 1'b0;
        periph_o = 1'b0;
        host_o   = 1'b0;
        inert_o  = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_REINIT: reinit_o = 1'b1;
            ST_PERIPH: periph_o = 1'b1;
            ST_HOST:   host_o   = 1'b1;
            ST_INERT:  inert_o  = 1'b1;
            default:   ;
        endcase
    end

    // R3: the reinitialise pulse lasts one cycle unless retriggered
    a_r3_reinit_single: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_o && !newmode_i) |=> !reinit_o);
    // R3: a new-mode write always produces the pulse next cycle
    a_r3_reinit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        newmode_i |=> reinit_o);
    // R4: at most one activity output at a time
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reinit_o, periph_o, host_o, inert_o}));
endmodule

// File: rtl/ppc_flags.sv
module ppc_flags
    import ppc_pkg::*;
#(
    parameter logic [NFLAG-1:0] ENTRY_MASK = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             entry_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic [NFLAG-1:0] en_i,
    output logic [NFLAG-1:0] flag_o,
    output logic             irq_o
);
    logic [NFLAG-1:0] flg_q, elig_q;

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        logic silent;
        assign silent = ENTRY_MASK[k] && entry_i;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flg_q[k]  <= 1'b0;
                elig_q[k] <= 1'b0;
            end else if (set_i[k]) begin
                flg_q[k]  <= 1'b1;
                elig_q[k] <= elig_q[k] || !silent;
            end else if (clr_i[k]) begin
                flg_q[k]  <= 1'b0;
                elig_q[k] <= 1'b0;
            end
        end

        // R5: a flag first set by mode entry is latched but not eligible
        a_r5_entry_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[k] && silent && !flg_q[k]) |=> (flg_q[k] && !elig_q[k]));
        // R7: a clear without a coincident event drops the flag
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flg_q[k]);
        // R7: an event wins over a clear in the same cycle
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flg_q[k]);
    end

    assign flag_o = flg_q;
    assign irq_o  = |(flg_q & elig_q & en_i);

    // R6: no request while every enable is clear
    a_r6_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/ppc_line_ovr.sv
module ppc_line_ovr
    import ppc_pkg::*;
(
    input  logic             periph_i,
    input  logic [NLINE-1:0] hi_i,
    input  logic [NLINE-1:0] lo_i,
    input  logic [NLINE-1:0] sm_i,
    output logic [NLINE-1:0] pin_o
);
    for (genvar i = 0; i < NLINE; i++) begin : g_line
        always_comb begin
            if (!periph_i)   pin_o[i] = sm_i[i];
            else if (lo_i[i]) pin_o[i] = 1'b0;
            else if (hi_i[i]) pin_o[i] = 1'b1;
            else              pin_o[i] = sm_i[i];
        end
    end
endmodule

// File: rtl/ppc_mode_ctrl.sv
module ppc_mode_ctrl
    import ppc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cpu_addr,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       ev_idle,
    input  logic       ev_dreq,
    input  logic       ev_stat,
    input  logic       ev_entry,
    input  logic [3:0] sm_lines,
    output logic [3:0] pin_lines,
    output logic [3:0] mode_sel,
    output logic       reinit,
    output logic       periph_act,
    output logic       host_act,
    output logic       mode_inert,
    output logic       irq
);
    logic [NFLAG-1:0] flags, en, clr, set_vec;
    logic [NLINE-1:0] ovr_hi, ovr_lo;
    logic             newmode;

    always_comb begin
        set_vec           = '0;
        set_vec[FLG_IDLE] = ev_idle;
        set_vec[FLG_DREQ] = ev_dreq;
        set_vec[FLG_STAT] = ev_stat;
    end

    ppc_regfile #(.AW(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd),
        .wdata(cpu_wdata), .flags_i(flags), .irq_i(irq), .mode_o(mode_sel),
        .en_o(en), .ovr_hi_o(ovr_hi), .ovr_lo_o(ovr_lo), .newmode_o(newmode),
        .clr_o(clr), .rdata_o(cpu_rdata)
    );

    ppc_ctl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .newmode_i(newmode), .mode_i(mode_sel),
        .reinit_o(reinit), .periph_o(periph_act), .host_o(host_act),
        .inert_o(mode_inert)
    );

    ppc_flags #(.ENTRY_MASK(3'b011)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .entry_i(ev_entry || reinit),
        .clr_i(clr), .en_i(en), .flag_o(flags), .irq_o(irq)
    );

    ppc_line_ovr u_ovr (
        .periph_i(periph_act), .hi_i(ovr_hi), .lo_i(ovr_lo),
        .sm_i(sm_lines), .pin_o(pin_lines)
    );

    // R9: outside peripheral operation the lines pass straight through
    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_act |-> (pin_lines == sm_lines));
    // R4: peripheral operation is only reached for a peripheral mode code
    a_r4_periph_code: assert property (@(posedge clk) disable iff (!rst_n)
        periph_act |-> (!mode_sel[3] && mode_sel != 4'h0));
endmodule

// File: tb/ppc_mode_ctrl_bench.sv
`timescale 1ns/1ps
module ppc_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ev_idle = 1'b0, ev_dreq = 1'b0, ev_stat = 1'b0, ev_entry = 1'b0;
    logic [3:0] sm_lines = '0;
    logic [3:0] pin_lines, mode_sel;
    logic       reinit, periph_act, host_act, mode_inert, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ppc_mode_ctrl u_ppc_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ev_idle(ev_idle), .ev_dreq(ev_dreq), .ev_stat(ev_stat), .ev_entry(ev_entry),
        .sm_lines(sm_lines), .pin_lines(pin_lines), .mode_sel(mode_sel),
        .reinit(reinit), .periph_act(periph_act), .host_act(host_act),
        .mode_inert(mode_inert), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        cpu_rd = 1'b0;
        #0.1;
    endtask

    task automatic pulse(input int k, input bit entry);
        ev_idle = (k == 0); ev_dreq = (k == 1); ev_stat = (k == 2); ev_entry = entry;
        @(negedge clk);
        ev_idle = 0; ev_dreq = 0; ev_stat = 0; ev_entry = 0;
    endtask

    function automatic logic [2:0] exp_act(input logic [3:0] m); // {periph,host,inert}
        if (m == 4'h0) return 3'b000;
        if (!m[3])     return 3'b100;
        if (m == 4'hD) return 3'b001;
        return 3'b010;
    endfunction

    function automatic logic [3:0] exp_pin(input logic [7:0] ov, input logic [3:0] sm, input bit per);
        logic [3:0] r;
        if (!per) return sm;
        for (int i = 0; i < 4; i++)
            r[i] = ov[i] ? 1'b0 : (ov[4+i] ? 1'b1 : sm[i]);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            report();
        end
    end

    initial begin
        logic [7:0] d;
        logic [2:0] a;
        repeat (3) @(negedge clk);
        sm_lines = 4'hA;
        #0.5;
        // R1 reset state
        chk({mode_sel, reinit, periph_act, host_act, mode_inert, irq} == 9'h0, "R1",
            {mode_sel, reinit, periph_act, host_act, mode_inert, irq}, 0);
        chk(pin_lines == sm_lines, "R1", pin_lines, sm_lines);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'hD9, d); chk(d == 8'h00, "R1", d, 0);
        rd(8'hDB, d); chk(d == 8'h00, "R1", d, 0);

        // R3 R4: sweep every mode code
        for (int m = 0; m < 16; m++) begin
            wr(8'hD9, 8'h80 | m[7:0]);
            chk(reinit === 1'b1 && mode_sel == m[3:0], "R3", {reinit, mode_sel}, {1'b1, m[3:0]});
            @(negedge clk);
            a = exp_act(m[3:0]);
            chk(!reinit && {periph_act, host_act, mode_inert} == a, "R4",
                {reinit, periph_act, host_act, mode_inert}, {1'b0, a});
        end

        // R2: enables update without new-mode, mode unchanged, bit 7 reads 0
        wr(8'hD9, 8'h80 | 8'h3); @(negedge clk);
        wr(8'hD9, 8'h7C);
        chk(mode_sel == 4'h3 && !reinit, "R2", {reinit, mode_sel}, 4'h3);
        rd(8'hD9, d); chk(d == 8'h73, "R2", d, 8'h73);
        wr(8'hD9, 8'hF5); @(negedge clk);
        rd(8'hD9, d); chk(d == 8'h75, "R2", d, 8'h75);

        // R8: peripheral mode, every override byte, two line patterns
        wr(8'hD9, 8'h81); @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            wr(8'hDB, v[7:0]);
            for (int s = 0; s < 2; s++) begin
                sm_lines = s ? 4'h5 : 4'hA; #0.5;
                chk(pin_lines == exp_pin(v[7:0], sm_lines, 1'b1), "R8",
                    pin_lines, exp_pin(v[7:0], sm_lines, 1'b1));
            end
        end
        // R9: host mode and the reinit cycle ignore overrides
        wr(8'hDB, 8'h0F);
        wr(8'hD9, 8'h89);
        sm_lines = 4'hF; #0.5;
        chk(pin_lines == 4'hF, "R9", pin_lines, 4'hF);
        @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            wr(8'hDB, v[7:0]);
            sm_lines = v[3:0] ^ v[7:4]; #0.5;
            chk(pin_lines == sm_lines, "R9", pin_lines, sm_lines);
        end
        wr(8'hD9, 8'h8D); @(negedge clk);
        wr(8'hDB, 8'hF0); sm_lines = 4'h0; #0.5;
        chk(pin_lines == 4'h0, "R9", pin_lines, 0);

        // R6 R7: every enable combination against every flag
        for (int e = 0; e < 8; e++) begin
            for (int k = 0; k < 3; k++) begin
                wr(8'hD9, {1'b0, e[0], e[2], e[1], 4'h0});
                pulse(k, 1'b0);
                chk(irq == e[k], "R6", irq, e[k]);
                rd(8'hDA, d);
                chk(d == ({e[k], 7'h0} | (8'h1 << k)), "R7", d, {e[k], 7'h0} | (8'h1 << k));
                wr(8'hDA, 8'h1 << k);
                rd(8'hDA, d);
                chk(d == 8'h00 && !irq, "R7", d, 0);
            end
        end

        // R5 R11: entry-qualified events
        wr(8'hD9, 8'h70);
        pulse(0, 1'b1); rd(8'hDA, d);
        chk(d == 8'h01 && !irq, "R5", d, 8'h01);
        pulse(1, 1'b1); rd(8'hDA, d);
        chk(d == 8'h03 && !irq, "R5", d, 8'h03);
        pulse(2, 1'b1); rd(8'hDA, d);
        chk(d == 8'h87 && irq, "R11", d, 8'h87);
        wr(8'hDA, 8'h07);
        // R5: DREQ raised during the reinitialise cycle
        wr(8'hD9, 8'hF1);
        pulse(1, 1'b0);
        rd(8'hDA, d);
        chk(d == 8'h02 && !irq, "R5", d, 8'h02);
        wr(8'hDA, 8'h02);
        // R7: event and clear in the same cycle keeps the flag
        ev_idle = 1'b1;
        wr(8'hDA, 8'h01);
        ev_idle = 1'b0;
        rd(8'hDA, d);
        chk(d == 8'h81 && irq, "R7", d, 8'h81);
        wr(8'hDA, 8'h01);

        // R10: unmapped address and idle read port
        rd(8'h00, d); chk(d == 8'h00, "R10", d, 0);
        cpu_addr = 8'hD9; #0.5;
        chk(cpu_rdata == 8'h00, "R10", cpu_rdata, 0);

        done = 1'b1;
        report();
    end
endmodule